// File: doc/BRIEF.md
# Multi-Channel ADC Sample Sequencer

The sequencer walks a programmable list of up to eight analog channel numbers and asks an external converter for one conversion per list slot. The converter side is abstract: the block raises a one-cycle start pulse together with the channel number, and the converter later returns a 12-bit result with a one-cycle done strobe. Every result is written into a 32-entry FIFO, tagged with the channel that produced it. Software reads the FIFO one entry at a time through a small word-addressed register port.

A run begins when the start bit is written together with the enable bit. In single-pass mode the sequencer visits slots 0 up to the programmed last-slot index once and returns to idle. In continuous mode it wraps to slot 0 until stopped. Between two conversions of a run it waits (count+1) ticks of a selectable time base. A stop request lets the conversion in flight finish and store its result, then the sequencer goes idle. Results that arrive while the FIFO is full are discarded and a sticky overflow flag records the loss.

Register map (word address on `reg_addr`): 0 control (bit 0 enable, bit 1 continuous, bit 2 start, bit 3 stop; start and stop read back as 0); 1 channel list (slot i in bits 3i+2:3i, last-slot index in bits 26:24); 2 gap timing (count in bits 7:0, time-base select in bits 9:8, one tick = 4^select clock cycles); 3 status; 4 FIFO data.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the status word reads 0x1000 (only the empty flag set) and `conv_start` is low.
- R2: Writing the start bit (control bit 2) while the written enable bit (control bit 0) is 0 launches no conversion and the busy bit stays 0.
- R3: A run started by writing control with bits 0 and 2 set, continuous bit 1 clear, issues exactly (last-slot index + 1) conversions whose `conv_chan` values are slots 0, 1, ... in order, each `conv_start` one cycle wide; a last-slot index of 0 gives a single conversion.
- R4: With continuous bit 1 set the slot order wraps from the last slot back to slot 0; writing control bit 3 (stop) lets the conversion in flight complete, after which no further `conv_start` occurs and busy clears.
- R5: A read of address 4 returns the oldest stored result with the sample in bits 11:0 and the channel tag in bits 14:12, and removes it; entries come out in conversion order.
- R6: Status (address 3) holds busy in bits 2:0 (bit 0 set while a run is active, bits 2:1 zero), the channel of the current slot in bits 5:3, the entry count modulo 32 in bits 10:6, full in bit 11, empty in bit 12 and overflow in bit 13; full and empty are never set together.
- R7: Within a run, the next `conv_start` comes exactly G+1 cycles after the cycle in which `conv_done` was high, where G = (count+1)·4^select.
- R8: With 32 entries stored, status shows full set and a count field of 0; any further result is dropped, sets the overflow bit, which stays set until a write to address 3 with bit 13 set clears it.
- R9: Busy is set in every cycle from the start pulse onward until the sequencer returns to idle.
- R10: A read of address 4 while the FIFO is empty returns 0 and leaves the count and contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at address 4) |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel for the requested conversion |
| conv_done | input | 1 | Converter result valid strobe |
| conv_data | input | 12 | Converter result |

## Verification
The bench attacks the single-slot list, where an off-by-one in the last-slot compare would give zero or two conversions, and the continuous wrap, where a missing wrap would walk into unprogrammed slots. It stops a continuous run mid-flight: a design that aborts the active conversion would show more starts than results, one that ignores the stop would keep pulsing `conv_start`. It fills the FIFO past 32 entries to catch a count that overwrites old data or a sticky flag that clears by itself, and measures every inter-sample gap under random count and time-base values, which exposes a timer that is one cycle short or scales by the wrong power.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_LAUNCH = 2'd1,
      SQ_WAIT   = 2'd2,
      SQ_GAP    = 2'd3
   } seq_state_e;

   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_LIST  = 3'd1;
   localparam logic [2:0] A_TIME  = 3'd2;
   localparam logic [2:0] A_STAT  = 3'd3;
   localparam logic [2:0] A_FIFO  = 3'd4;

   localparam int B_EN    = 0;
   localparam int B_CONT  = 1;
   localparam int B_START = 2;
   localparam int B_STOP  = 3;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int SLOTS   = 8,
   parameter int CH_W    = 3,
   parameter int DCNT_W  = 8,
   parameter int TB_W    = 2,
   parameter int OVF_BIT = 13,
   localparam int IDX_W  = $clog2(SLOTS),
   localparam int LIST_W = SLOTS * CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              ovf_set,
   output logic              en,
   output logic              cont,
   output logic              start_go,
   output logic              stop_req,
   output logic              ovf_clr,
   output logic [LIST_W-1:0] list_slots,
   output logic [IDX_W-1:0]  max_idx,
   output logic [DCNT_W-1:0] dly_cnt,
   output logic [TB_W-1:0]   tb_sel,
   output logic              ovf
);
   logic wr_ctrl;

   if (LIST_W + IDX_W > 32) begin : g_list_fit
      $error("channel list does not fit one register word");
   end
   if (DCNT_W + TB_W > 32) begin : g_time_fit
      $error("gap timing does not fit one register word");
   end

   assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
   assign start_go = wr_ctrl && reg_wdata[B_START] && reg_wdata[B_EN];
   assign stop_req = (wr_ctrl && (reg_wdata[B_STOP] || !reg_wdata[B_EN])) || !en;
   assign ovf_clr  = reg_wr && (reg_addr == A_STAT) && reg_wdata[OVF_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en         <= 1'b0;
         cont       <= 1'b0;
         list_slots <= '0;
         max_idx    <= '0;
         dly_cnt    <= '0;
         tb_sel     <= '0;
         ovf        <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            en   <= reg_wdata[B_EN];
            cont <= reg_wdata[B_CONT];
         end
         if (reg_wr && (reg_addr == A_LIST)) begin
            list_slots <= reg_wdata[LIST_W-1:0];
            max_idx    <= reg_wdata[LIST_W +: IDX_W];
         end
         if (reg_wr && (reg_addr == A_TIME)) begin
            dly_cnt <= reg_wdata[DCNT_W-1:0];
            tb_sel  <= reg_wdata[DCNT_W +: TB_W];
         end
         if (ovf_set)      ovf <= 1'b1;
         else if (ovf_clr) ovf <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int SLOTS   = 8,
   parameter int CH_W    = 3,
   parameter int DCNT_W  = 8,
   parameter int TB_W    = 2,
   parameter int TB_STEP = 2,
   localparam int IDX_W  = $clog2(SLOTS),
   localparam int LIST_W = SLOTS * CH_W,
   localparam int SH_MAX = ((1 << TB_W) - 1) * TB_STEP,
   localparam int TMR_W  = DCNT_W + 1 + SH_MAX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cont,
   input  logic              start_go,
   input  logic              stop_req,
   input  logic [LIST_W-1:0] list_slots,
   input  logic [IDX_W-1:0]  max_idx,
   input  logic [DCNT_W-1:0] dly_cnt,
   input  logic [TB_W-1:0]   tb_sel,
   input  logic              conv_done,
   output logic              conv_start,
   output logic [CH_W-1:0]   cur_chan,
   output logic              push,
   output logic              busy
);
   seq_state_e       state;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] idx_next;
   logic [TMR_W-1:0] timer;
   logic [TMR_W-1:0] gap_m1;
   logic             stop_pend;
   logic             last_slot;
   logic [CH_W-1:0]  slot [SLOTS];

   if (SLOTS != (1 << IDX_W) || SLOTS < 2) begin : g_slots_pow2
      $error("SLOTS must be a power of two, at least 2");
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign slot[g] = list_slots[g*CH_W +: CH_W];
   end

   if (TB_STEP == 0) begin : g_tb_flat
      assign gap_m1 = TMR_W'(dly_cnt);
   end else begin : g_tb_scaled
      assign gap_m1 = ((TMR_W'(dly_cnt) + TMR_W'(1)) << (tb_sel * TB_STEP)) - TMR_W'(1);
   end

   assign cur_chan   = slot[idx];
   assign last_slot  = (idx == max_idx);
   assign idx_next   = last_slot ? '0 : idx + IDX_W'(1);
   assign conv_start = (state == SQ_LAUNCH);
   assign push       = (state == SQ_WAIT) && conv_done;
   assign busy       = (state != SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         idx       <= '0;
         timer     <= '0;
         stop_pend <= 1'b0;
      end else begin
         case (state)
            SQ_IDLE: begin
               stop_pend <= 1'b0;
               if (start_go) begin
                  idx   <= '0;
                  state <= SQ_LAUNCH;
               end
            end
            SQ_LAUNCH: begin
               state <= SQ_WAIT;
               if (stop_req) stop_pend <= 1'b1;
            end
            SQ_WAIT: begin
               if (stop_req) stop_pend <= 1'b1;
               if (conv_done) begin
                  if (stop_pend || stop_req || (last_slot && !cont)) begin
                     state <= SQ_IDLE;
                  end else begin
                     idx   <= idx_next;
                     timer <= gap_m1;
                     state <= SQ_GAP;
                  end
               end
            end
            default: begin
               if (stop_pend || stop_req)  state <= SQ_IDLE;
               else if (timer == '0)       state <= SQ_LAUNCH;
               else                        timer <= timer - TMR_W'(1);
            end
         endcase
      end
   end
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
   parameter int DEPTH  = 32,
   parameter int W      = 15,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] occ,
   output logic             full,
   output logic             empty,
   output logic             drop
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr;
   logic [AW-1:0] rptr;
   logic          do_wr;
   logic          do_rd;

   if (DEPTH != (1 << AW) || DEPTH < 2) begin : g_depth_pow2
      $error("FIFO depth must be a power of two, at least 2");
   end

   assign full  = (occ == CNT_W'(DEPTH));
   assign empty = (occ == '0);
   assign do_wr = push && !full;
   assign do_rd = pop && !empty;
   assign drop  = push && full;
   assign dout  = empty ? '0 : mem[rptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         occ  <= '0;
      end else begin
         if (do_wr) wptr <= wptr + AW'(1);
         if (do_rd) rptr <= rptr + AW'(1);
         case ({do_wr, do_rd})
            2'b10:   occ <= occ + CNT_W'(1);
            2'b01:   occ <= occ - CNT_W'(1);
            default: occ <= occ;
         endcase
      end
   end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
   import adc_seq_pkg::*;
#(
   parameter int SLOTS   = 8,
   parameter int CH_W    = 3,
   parameter int SMP_W   = 12,
   parameter int DEPTH   = 32,
   parameter int DCNT_W  = 8,
   parameter int TB_W    = 2,
   parameter int TB_STEP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              conv_start,
   output logic [CH_W-1:0]   conv_chan,
   input  logic              conv_done,
   input  logic [SMP_W-1:0]  conv_data
);
   localparam int IDX_W   = $clog2(SLOTS);
   localparam int LIST_W  = SLOTS * CH_W;
   localparam int AW      = $clog2(DEPTH);
   localparam int CNT_W   = AW + 1;
   localparam int ENT_W   = SMP_W + CH_W;
   localparam int ST_CHAN = 3;
   localparam int ST_CNT  = ST_CHAN + CH_W;
   localparam int ST_FULL = ST_CNT + AW;
   localparam int ST_EMPT = ST_FULL + 1;
   localparam int ST_OVF  = ST_FULL + 2;

   if (ENT_W > 32 || ST_OVF > 31) begin : g_word_fit
      $error("FIFO entry or status does not fit one register word");
   end

   logic              en_r;
   logic              cont_r;
   logic              start_go;
   logic              stop_req;
   logic              ovf_clr;
   logic              ovf_flag;
   logic [LIST_W-1:0] list_slots;
   logic [IDX_W-1:0]  max_idx;
   logic [DCNT_W-1:0] dly_cnt;
   logic [TB_W-1:0]   tb_sel;
   logic [CH_W-1:0]   cur_chan;
   logic              seq_busy;
   logic              fifo_push;
   logic              fifo_pop;
   logic              fifo_full;
   logic              fifo_empty;
   logic              fifo_drop;
   logic [ENT_W-1:0]  fifo_dout;
   logic [CNT_W-1:0]  fifo_occ;
   logic [31:0]       status;

   adc_seq_regs #(
      .SLOTS(SLOTS), .CH_W(CH_W), .DCNT_W(DCNT_W), .TB_W(TB_W), .OVF_BIT(ST_OVF)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .ovf_set(fifo_drop), .en(en_r), .cont(cont_r),
      .start_go(start_go), .stop_req(stop_req), .ovf_clr(ovf_clr),
      .list_slots(list_slots), .max_idx(max_idx), .dly_cnt(dly_cnt),
      .tb_sel(tb_sel), .ovf(ovf_flag)
   );

   adc_seq_ctrl #(
      .SLOTS(SLOTS), .CH_W(CH_W), .DCNT_W(DCNT_W), .TB_W(TB_W), .TB_STEP(TB_STEP)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cont(cont_r), .start_go(start_go),
      .stop_req(stop_req), .list_slots(list_slots), .max_idx(max_idx),
      .dly_cnt(dly_cnt), .tb_sel(tb_sel), .conv_done(conv_done),
      .conv_start(conv_start), .cur_chan(cur_chan), .push(fifo_push),
      .busy(seq_busy)
   );

   assign fifo_pop  = reg_rd && (reg_addr == A_FIFO);
   assign conv_chan = cur_chan;

   adc_seq_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(fifo_push), .din({cur_chan, conv_data}),
      .pop(fifo_pop), .dout(fifo_dout), .occ(fifo_occ), .full(fifo_full),
      .empty(fifo_empty), .drop(fifo_drop)
   );

   always_comb begin
      status                        = '0;
      status[0]                     = seq_busy;
      status[ST_CHAN +: CH_W]       = cur_chan;
      status[ST_CNT +: AW]          = fifo_occ[AW-1:0];
      status[ST_FULL]               = fifo_full;
      status[ST_EMPT]               = fifo_empty;
      status[ST_OVF]                = ovf_flag;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[B_EN]   = en_r;
            reg_rdata[B_CONT] = cont_r;
         end
         A_LIST: reg_rdata = 32'({max_idx, list_slots});
         A_TIME: reg_rdata = 32'({tb_sel, dly_cnt});
         A_STAT: reg_rdata = status;
         A_FIFO: reg_rdata = 32'(fifo_dout);
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int DEPTH = 32,
   parameter int CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             conv_start,
   input logic             busy,
   input logic             push,
   input logic             full,
   input logic             empty,
   input logic             ovf,
   input logic             ovf_clr,
   input logic [CNT_W-1:0] occ
);
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start); // R3
   AST_BUSY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy); // R9
   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> busy); // R9
   AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R6
   AST_FULL_AT_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (occ == CNT_W'(DEPTH))); // R8
   AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> ovf); // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf); // R8
   AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (occ != $past(occ)) |-> ((occ == $past(occ) + CNT_W'(1)) || (occ == $past(occ) - CNT_W'(1)))); // R5
endmodule

bind adc_seq_top adc_seq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .busy(seq_busy),
   .push(fifo_push), .full(fifo_full), .empty(fifo_empty), .ovf(ovf_flag),
   .ovf_clr(ovf_clr), .occ(fifo_occ)
);

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        conv_start;
   logic [2:0]  conv_chan;
   logic        conv_done = 1'b0;
   logic [11:0] conv_data = 12'd0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int n_st = 0;
   int n_dn = 0;
   int pend = 0;
   int cur_ch = 0;
   int last_done = 0;
   bit done_valid = 0;
   int exp_gap = 1;
   int gap_err = 0;
   int gap_seen = 0;
   bit finished = 0;
   logic [2:0]  st_ch [4096];
   logic [14:0] exp_q [$];

   adc_seq_top dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
      .conv_data(conv_data)
   );

   initial forever #5 clk = ~clk;

   function automatic logic [11:0] sample_of(int ch, int n);
      return 12'((ch * 293 + n * 57 + 5) & 32'hfff);
   endfunction

   function automatic int gap_of(int cnt, int sel);
      return (cnt + 1) << (2 * sel);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // converter model and watchdog, all acting on the falling edge
   initial forever begin
      @(negedge clk);
      cyc++;
      conv_done = 1'b0;
      if (pend > 0) begin
         pend--;
         if (pend == 0) begin
            conv_done = 1'b1;
            conv_data = sample_of(cur_ch, n_dn);
            if (exp_q.size() < 32) exp_q.push_back({3'(cur_ch), conv_data});
            n_dn++;
            last_done = cyc;
            done_valid = 1;
         end
      end
      if (conv_start) begin
         if (n_st < 4096) st_ch[n_st] = conv_chan;
         if (done_valid) begin
            gap_seen++;
            if (cyc - last_done != exp_gap) begin
               gap_err++;
               $display("FAIL R7 gap actual=%0d expected=%0d", cyc - last_done, exp_gap);
            end
         end
         cur_ch = int'(conv_chan);
         n_st++;
         pend = 1 + int'($urandom % 5);
      end
      if (cyc > 150000 && !finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         finish_run();
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 40000; i++) begin
         rd(3'd3, s);
         if (s[0] == 1'b0) break;
      end
   endtask

   task automatic drain(input string req);
      logic [31:0] d;
      int n;
      n = exp_q.size();
      for (int i = 0; i < n; i++) begin
         logic [14:0] e;
         e = exp_q.pop_front();
         rd(3'd4, d);
         check(d == {17'd0, e}, req, d, {17'd0, e});
      end
   endtask

   function automatic logic [31:0] pack_list(logic [2:0] s0, logic [2:0] s1, logic [2:0] s2,
                                             logic [2:0] s3, logic [2:0] mx);
      return {5'd0, mx, 12'd0, s3, s2, s1, s0};
   endfunction

   task automatic run_single(input logic [31:0] list, input int cnt, input int sel);
      wr(3'd2, {22'd0, 2'(sel), 8'(cnt)});
      wr(3'd1, list);
      exp_gap = gap_of(cnt, sel) + 1;
      done_valid = 0;
      wr(3'd0, 32'h5);
      wait_idle();
   endtask

   initial begin
      logic [31:0] s;
      logic [31:0] d;
      int base;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd3, s);
      check(s == 32'h1000, "R1 status after reset", s, 32'h1000);
      check(conv_start == 1'b0, "R1 conv_start after reset", conv_start, 0);

      // R2 start without enable
      wr(3'd1, pack_list(3'd1, 3'd2, 3'd3, 3'd4, 3'd3));
      wr(3'd0, 32'h4);
      repeat (20) @(negedge clk);
      rd(3'd3, s);
      check(n_st == 0, "R2 no conversion without enable", n_st, 0);
      check(s[0] == 1'b0, "R2 busy stays clear", s[0], 0);

      // R3 single pass over three slots, R5 FIFO order and format
      base = n_st;
      run_single(pack_list(3'd5, 3'd2, 3'd7, 3'd0, 3'd2), 0, 0);
      check(n_st - base == 3, "R3 three conversions", n_st - base, 3);
      check(st_ch[base] == 3'd5 && st_ch[base+1] == 3'd2 && st_ch[base+2] == 3'd7,
            "R3 slot order", {st_ch[base], st_ch[base+1], st_ch[base+2]}, 9'o527);
      rd(3'd3, s);
      check(s[0] == 1'b0 && s[10:6] == 5'd3 && s[12:11] == 2'b00, "R6 status after pass",
            s & 32'h3fc7, 32'h00c0);
      drain("R5 fifo entry");
      rd(3'd4, d);
      check(d == 32'd0, "R10 empty read value", d, 0);
      rd(3'd3, s);
      check(s[12] == 1'b1 && s[10:6] == 5'd0, "R10 empty read keeps count", s & 32'h3fc7, 32'h1000);

      // R3 single slot
      base = n_st;
      run_single(pack_list(3'd6, 3'd1, 3'd1, 3'd1, 3'd0), 0, 0);
      check(n_st - base == 1 && st_ch[base] == 3'd6, "R3 single slot", n_st - base, 1);
      drain("R5 single entry");

      // R7 directed gap, then random runs
      gap_err = 0; gap_seen = 0;
      run_single(pack_list(3'd0, 3'd3, 3'd4, 3'd1, 3'd3), 3, 1);
      drain("R5 directed gap entry");
      for (int k = 0; k < 5; k++) begin
         run_single(pack_list(3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
                              3'($urandom % 4)), int'($urandom % 24), int'($urandom % 3));
         drain("R5 random run entry");
      end
      check(gap_err == 0, "R7 gap errors", gap_err, 0);
      check(gap_seen >= 3, "R7 gaps observed", gap_seen, 3);

      // R6 current channel and busy mid-run
      wr(3'd2, {22'd0, 2'd0, 8'd255});
      wr(3'd1, pack_list(3'd6, 3'd6, 3'd0, 3'd0, 3'd1));
      exp_gap = 257; done_valid = 0;
      base = n_dn;
      wr(3'd0, 32'h5);
      while (n_dn == base) @(negedge clk);
      repeat (4) @(negedge clk);
      rd(3'd3, s);
      check(s[2:0] == 3'b001 && s[5:3] == 3'd6, "R6 busy and channel mid-run", s[5:0], 6'o61);
      wait_idle();
      drain("R5 mid-run entry");

      // R4 continuous wrap and stop
      wr(3'd2, {22'd0, 2'd0, 8'd2});
      wr(3'd1, pack_list(3'd3, 3'd7, 3'd1, 3'd4, 3'd3));
      exp_gap = gap_of(2, 0) + 1; done_valid = 0;
      base = n_st;
      wr(3'd0, 32'h7);
      while (n_st - base < 10) @(negedge clk);
      wr(3'd0, 32'hb);
      wait_idle();
      check(n_st == n_dn, "R4 conversion in flight completes", n_dn, n_st);
      begin
         bit ok;
         logic [2:0] pat [4];
         pat[0] = 3'd3; pat[1] = 3'd7; pat[2] = 3'd1; pat[3] = 3'd4;
         ok = 1;
         for (int i = base; i < n_st; i++) if (st_ch[i] != pat[(i - base) % 4]) ok = 0;
         check(ok, "R4 wrap order", ok, 1);
      end
      d = 32'(n_st);
      repeat (60) @(negedge clk);
      check(n_st == int'(d), "R4 no start after stop", n_st, d);
      rd(3'd3, s);
      check(s[0] == 1'b0, "R4 busy clear after stop", s[0], 0);
      drain("R5 continuous entry");

      // R8 overflow: fill past 32 entries
      wr(3'd2, 32'd0);
      wr(3'd1, pack_list(3'd2, 3'd5, 3'd0, 3'd0, 3'd1));
      exp_gap = 2; done_valid = 0;
      base = n_st;
      wr(3'd0, 32'h7);
      while (n_st - base < 40) @(negedge clk);
      wr(3'd0, 32'h9);
      wait_idle();
      rd(3'd3, s);
      check((s & 32'h3fc7) == 32'h2800, "R8 full, count 0, overflow", s & 32'h3fc7, 32'h2800);
      wr(3'd3, 32'h2000);
      rd(3'd3, s);
      check(s[13] == 1'b0 && s[11] == 1'b1, "R8 overflow cleared, still full", s & 32'h3fc7, 32'h0800);
      check(exp_q.size() == 32, "R8 expected entries kept", exp_q.size(), 32);
      drain("R8 oldest entries kept");
      rd(3'd3, s);
      check((s & 32'h3fc7) == 32'h1000, "R8 empty after drain", s & 32'h3fc7, 32'h1000);

      finished = 1;
      finish_run();
   end
endmodule